// File: doc/BRIEF.md
# Peak-Hold Sweep Trace Recorder

This block captures one amplitude-versus-position trace into an external 1024 x 8 memory while a sweep runs. A 10-bit position code climbs from 0 to 1023 over the sweep, and a stream of 8-bit amplitude samples arrives alongside it, each qualified by a valid strobe. Each position value marks a segment. While the code holds one value, the block keeps the largest valid amplitude it has seen. When the code moves, the block writes that peak into the memory word for the segment that just closed and starts a new peak from the sample that arrives with the new code.

The position code and the samples pass through two register stages before the segment logic sees them. The memory write is presented as an active-low write strobe with address and data. A pass from code 1023 back to 0 closes the final segment and raises a one-cycle sweep-done flag. A busy output shows that a segment is being measured. Every sweep overwrites each address once, so the memory always holds the latest full trace.

Top module: `sweep_peak_recorder`

## Requirements
- R1: Each write goes to the address equal to the position code of the segment that has just ended, not the new code.
- R2: The written word is the largest amplitude among the valid samples that were presented while the segment's code was held.
- R3: A sample presented with amp_valid low has no effect on any stored peak.
- R4: A new segment's peak starts from the sample presented with the first cycle of the new code (zero if that sample is not valid). The previous segment's peak is not carried over.
- R5: The write strobe mem_we_n is active low. For each change of position code it goes low for exactly one cycle, on the third rising clock edge counted from the edge that first captures the new code.
- R6: A change of the code by more than one count produces exactly one write, for the segment that was left. No addresses in between are written.
- R7: When the code goes from 1023 to 0, the segment at 1023 is written, and sweep_done is high for exactly that one write cycle.
- R8: Reset is synchronous and active high. It clears the held peak and the segment-tracking state. mem_we_n stays high during reset and in the cycle after it, so a code change that was still in the pipeline when reset arrived is never written.
- R9: busy is low in reset and goes high on the third rising edge after reset is released. The first segment after reset produces no write until its code changes. No write occurs while busy is low.
- R10: As long as the position code does not change, mem_we_n stays high whatever the amplitude samples do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pos_code | input | 10 | Sweep position code, 0 at sweep start, 1023 at end |
| amp_data | input | 8 | Amplitude sample |
| amp_valid | input | 1 | High when amp_data carries a sample |
| mem_we_n | output | 1 | Trace memory write strobe, low = write |
| mem_addr | output | 10 | Trace memory address for the write |
| mem_wdata | output | 8 | Peak word to be written |
| sweep_done | output | 1 | One-cycle pulse with the write that closes segment 1023 |
| busy | output | 1 | High while a segment's peak is being measured |

## Verification
The main table drives segments in several ways. In one, the peak falls in the middle of the segment, which separates a true maximum from the first or the last sample. In another, a large sample arrives with valid low, which exposes a comparator that ignores the strobe. A segment whose peak is only its first sample shows whether the peak register is seeded or cleared. A segment that opens on an invalid sample and follows a 200 peak shows that no old peak is carried over. A jump from code 2 to 5 confirms that only one write is made and that it goes to the right address. Directed runs then cover the 1023 to 0 wrap with its done pulse, and a reset that arrives while a change is still in the pipeline, which must produce no write at all.

// File: rtl/spr_pkg.sv
package spr_pkg;

    // Segment event produced by the peak tracker, consumed by the write port
    typedef enum logic [1:0] {
        EVT_NONE = 2'd0,
        EVT_SEG  = 2'd1,
        EVT_WRAP = 2'd2
    } evt_e;

endpackage

// File: rtl/spr_code_sync.sv
module spr_code_sync #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 8,
    parameter int STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] code_i,
    input  logic [AMP_W-1:0]  amp_i,
    input  logic              vld_i,
    output logic [ADDR_W-1:0] code_o,
    output logic [AMP_W-1:0]  amp_o,
    output logic              vld_o,
    output logic              live_o
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][ADDR_W-1:0] code;
        logic [STAGES-1:0][AMP_W-1:0]  amp;
        logic [STAGES-1:0]             vld;
        logic [STAGES-1:0]             live;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.code[0] = code_i;
        st_d.amp[0]  = amp_i;
        st_d.vld[0]  = vld_i;
        st_d.live[0] = 1'b1;
        for (int i = 1; i < STAGES; i++) begin
            st_d.code[i] = st_q.code[i-1];
            st_d.amp[i]  = st_q.amp[i-1];
            st_d.vld[i]  = st_q.vld[i-1];
            st_d.live[i] = st_q.live[i-1];
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign code_o = st_q.code[LAST];
    assign amp_o  = st_q.amp[LAST];
    assign vld_o  = st_q.vld[LAST];
    assign live_o = st_q.live[LAST];

    // once the pipeline has filled it stays filled until reset
    AST_LIVE_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        live_o |=> live_o); // R9

endmodule

// File: rtl/spr_peak_track.sv
module spr_peak_track
    import spr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] code_i,
    input  logic [AMP_W-1:0]  amp_i,
    input  logic              vld_i,
    input  logic              live_i,
    output logic [ADDR_W-1:0] seg_code_o,
    output logic [AMP_W-1:0]  peak_o,
    output evt_e              evt_o,
    output logic              primed_o
);

    localparam logic [ADDR_W-1:0] LAST_CODE  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] FIRST_CODE = '0;

    typedef struct packed {
        logic [ADDR_W-1:0] seg;
        logic [AMP_W-1:0]  peak;
        logic              primed;
    } trk_t;

    trk_t trk_d, trk_q;
    logic             moved;
    logic             wrapped;
    logic [AMP_W-1:0] seed;

    always_comb begin
        moved   = live_i && trk_q.primed && (code_i != trk_q.seg);
        wrapped = moved && (trk_q.seg == LAST_CODE) && (code_i == FIRST_CODE);
        seed    = vld_i ? amp_i : '0;

        if (wrapped) begin
            evt_o = EVT_WRAP;
        end else if (moved) begin
            evt_o = EVT_SEG;
        end else begin
            evt_o = EVT_NONE;
        end

        trk_d = trk_q;
        if (rst_i) begin
            trk_d = '0;
        end else if (live_i && !trk_q.primed) begin
            trk_d.primed = 1'b1;
            trk_d.seg    = code_i;
            trk_d.peak   = seed;
        end else if (moved) begin
            trk_d.seg  = code_i;
            trk_d.peak = seed;
        end else if (trk_q.primed && vld_i && (amp_i > trk_q.peak)) begin
            trk_d.peak = amp_i;
        end
    end

    always_ff @(posedge clk_i) begin
        trk_q <= trk_d;
    end

    assign seg_code_o = trk_q.seg;
    assign peak_o     = trk_q.peak;
    assign primed_o   = trk_q.primed;

    AST_PEAK_MONOTONIC: assert property (@(posedge clk_i) disable iff (rst_i)
        (trk_q.primed && evt_o == EVT_NONE) |=> (trk_q.peak >= $past(trk_q.peak))); // R2

    AST_INVALID_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (trk_q.primed && evt_o == EVT_NONE && !vld_i) |=> $stable(trk_q.peak)); // R3

    AST_SEG_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
        (evt_o != EVT_NONE) |=> (trk_q.seg == $past(code_i))); // R6

endmodule

// File: rtl/spr_write_port.sv
module spr_write_port
    import spr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  evt_e              evt_i,
    input  logic [ADDR_W-1:0] seg_code_i,
    input  logic [AMP_W-1:0]  peak_i,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [AMP_W-1:0]  data_o,
    output logic              done_o
);

    localparam logic [ADDR_W-1:0] LAST_CODE = {ADDR_W{1'b1}};

    typedef struct packed {
        logic              we_n;
        logic [ADDR_W-1:0] addr;
        logic [AMP_W-1:0]  data;
        logic              done;
    } wr_t;

    wr_t wr_d, wr_q;

    always_comb begin
        wr_d      = wr_q;
        wr_d.we_n = (evt_i == EVT_NONE);
        wr_d.addr = seg_code_i;
        wr_d.data = peak_i;
        wr_d.done = (evt_i == EVT_WRAP);
        if (rst_i) begin
            wr_d      = '0;
            wr_d.we_n = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        wr_q <= wr_d;
    end

    assign we_n_o = wr_q.we_n;
    assign addr_o = wr_q.addr;
    assign data_o = wr_q.data;
    assign done_o = wr_q.done;

    AST_DONE_ON_LAST: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (!we_n_o && addr_o == LAST_CODE)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o); // R7

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> we_n_o); // R8

endmodule

// File: rtl/sweep_peak_recorder.sv
module sweep_peak_recorder
    import spr_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int AMP_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pos_code,
    input  logic [AMP_W-1:0]  amp_data,
    input  logic              amp_valid,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [AMP_W-1:0]  mem_wdata,
    output logic              sweep_done,
    output logic              busy
);

    logic [ADDR_W-1:0] s_code;
    logic [AMP_W-1:0]  s_amp;
    logic              s_vld;
    logic              s_live;
    logic [ADDR_W-1:0] seg_code;
    logic [AMP_W-1:0]  seg_peak;
    evt_e              seg_evt;
    logic              primed;

    spr_code_sync #(
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk),
        .rst_i  (rst),
        .code_i (pos_code),
        .amp_i  (amp_data),
        .vld_i  (amp_valid),
        .code_o (s_code),
        .amp_o  (s_amp),
        .vld_o  (s_vld),
        .live_o (s_live)
    );

    spr_peak_track #(
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W)
    ) u_track (
        .clk_i      (clk),
        .rst_i      (rst),
        .code_i     (s_code),
        .amp_i      (s_amp),
        .vld_i      (s_vld),
        .live_i     (s_live),
        .seg_code_o (seg_code),
        .peak_o     (seg_peak),
        .evt_o      (seg_evt),
        .primed_o   (primed)
    );

    spr_write_port #(
        .ADDR_W (ADDR_W),
        .AMP_W  (AMP_W)
    ) u_wport (
        .clk_i      (clk),
        .rst_i      (rst),
        .evt_i      (seg_evt),
        .seg_code_i (seg_code),
        .peak_i     (seg_peak),
        .we_n_o     (mem_we_n),
        .addr_o     (mem_addr),
        .data_o     (mem_wdata),
        .done_o     (sweep_done)
    );

    assign busy = primed;

    AST_ADDR_PREVIOUS: assert property (@(posedge clk) disable iff (rst)
        (seg_evt != EVT_NONE) |=> (!mem_we_n && mem_addr == $past(seg_code))); // R1

    AST_STILL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (seg_evt == EVT_NONE) |=> mem_we_n); // R10

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> mem_we_n); // R9

endmodule

// File: tb/sweep_peak_recorder_tb.sv
module sweep_peak_recorder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] pos_code = '0;
    logic [7:0] amp_data = '0;
    logic       amp_valid = 1'b0;
    logic       mem_we_n;
    logic [9:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       sweep_done;
    logic       busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    sweep_peak_recorder u_dut (
        .clk        (clk),
        .rst        (rst),
        .pos_code   (pos_code),
        .amp_data   (amp_data),
        .amp_valid  (amp_valid),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .sweep_done (sweep_done),
        .busy       (busy)
    );

    // Row: {code[38:29], amp[28:21], valid[20], exp_write[19], exp_addr[18:9], exp_data[8:1], exp_busy[0]}
    // Expectations of row i are sampled just before row i is driven (three edges after row i-3).
    localparam int NVEC = 19;
    localparam logic [38:0] VEC [NVEC] = '{
        {10'd0, 8'd10,  1'b1, 1'b0, 10'd0, 8'd0,   1'b0},
        {10'd0, 8'd50,  1'b1, 1'b0, 10'd0, 8'd0,   1'b0},  // R2 peak mid segment
        {10'd0, 8'd30,  1'b1, 1'b0, 10'd0, 8'd0,   1'b0},
        {10'd1, 8'd20,  1'b1, 1'b0, 10'd0, 8'd0,   1'b1},  // R9 busy up
        {10'd1, 8'd90,  1'b0, 1'b0, 10'd0, 8'd0,   1'b1},  // R3 invalid large sample
        {10'd1, 8'd40,  1'b1, 1'b0, 10'd0, 8'd0,   1'b1},
        {10'd2, 8'd5,   1'b1, 1'b1, 10'd0, 8'd50,  1'b1},  // R1 R5 seg 0 written
        {10'd2, 8'd5,   1'b0, 1'b0, 10'd0, 8'd0,   1'b1},
        {10'd5, 8'd7,   1'b1, 1'b0, 10'd0, 8'd0,   1'b1},  // R6 jump 2->5
        {10'd5, 8'd200, 1'b1, 1'b1, 10'd1, 8'd40,  1'b1},  // R3 seg 1 peak ignores 90
        {10'd6, 8'd0,   1'b0, 1'b0, 10'd0, 8'd0,   1'b1},
        {10'd6, 8'd0,   1'b0, 1'b1, 10'd2, 8'd5,   1'b1},  // R4 seeded by first sample
        {10'd7, 8'd3,   1'b1, 1'b0, 10'd0, 8'd0,   1'b1},
        {10'd7, 8'd3,   1'b1, 1'b1, 10'd5, 8'd200, 1'b1},  // R6 single write for 5
        {10'd7, 8'd255, 1'b1, 1'b0, 10'd0, 8'd0,   1'b1},
        {10'd7, 8'd1,   1'b1, 1'b1, 10'd6, 8'd0,   1'b1},  // R4 no carry of 200
        {10'd7, 8'd1,   1'b1, 1'b0, 10'd0, 8'd0,   1'b1},  // R10 code held
        {10'd7, 8'd1,   1'b1, 1'b0, 10'd0, 8'd0,   1'b1},
        {10'd7, 8'd1,   1'b1, 1'b0, 10'd0, 8'd0,   1'b1}
    };

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: sample outputs at the falling edge, then drive the next inputs
    task automatic step(input logic r, input logic [9:0] c, input logic [7:0] a,
                        input logic v, input logic chk, input logic xwr,
                        input logic [9:0] xaddr, input logic [7:0] xdata,
                        input logic xdone, input logic xbusy, input string tag);
        @(negedge clk);
        if (chk) begin
            check_eq({tag, " R5 write strobe"}, int'(mem_we_n), int'(!xwr));
            check_eq({tag, " R7 sweep_done"}, int'(sweep_done), int'(xdone));
            check_eq({tag, " R9 busy"}, int'(busy), int'(xbusy));
            if (xwr) begin
                check_eq({tag, " R1 address"}, int'(mem_addr), int'(xaddr));
                check_eq({tag, " R2 peak data"}, int'(mem_wdata), int'(xdata));
            end
        end
        rst       = r;
        pos_code  = c;
        amp_data  = a;
        amp_valid = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);

        // Table walk; row 0 also checks the reset state (R8)
        for (int i = 0; i < NVEC; i++) begin
            step(1'b0, VEC[i][38:29], VEC[i][28:21], VEC[i][20], 1'b1,
                 VEC[i][19], VEC[i][18:9], VEC[i][8:1], 1'b0, VEC[i][0],
                 $sformatf("table row %0d", i));
        end

        // R7: sweep wrap 1023 -> 0 flushes last segment and pulses done
        step(1'b1, 10'd0, 8'd0, 1'b0, 1'b0, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "wrap rst");
        step(1'b1, 10'd0, 8'd0, 1'b0, 1'b0, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "wrap rst");
        step(1'b0, 10'd1023, 8'd100, 1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "R8 wrap w0");
        step(1'b0, 10'd1023, 8'd60,  1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "R7 wrap w1");
        step(1'b0, 10'd1023, 8'd120, 1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "R7 wrap w2");
        step(1'b0, 10'd0,    8'd9,   1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b1, "R7 wrap w3");
        step(1'b0, 10'd0,    8'd0,   1'b0, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b1, "R7 wrap w4");
        step(1'b0, 10'd0,    8'd0,   1'b0, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b1, "R7 wrap w5");
        step(1'b0, 10'd0,    8'd0,   1'b0, 1'b1, 1'b1, 10'd1023, 8'd120, 1'b1, 1'b1, "R7 wrap w6");
        step(1'b0, 10'd0,    8'd0,   1'b0, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b1, "R7 wrap w7");

        // R8: reset lands while a code change is in the pipeline
        step(1'b1, 10'd0, 8'd0, 1'b0, 1'b0, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "rst pre");
        step(1'b1, 10'd0, 8'd0, 1'b0, 1'b0, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "rst pre");
        step(1'b0, 10'd5, 8'd10, 1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "R8 m0");
        step(1'b0, 10'd5, 8'd10, 1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "R8 m1");
        step(1'b0, 10'd5, 8'd10, 1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "R8 m2");
        step(1'b0, 10'd6, 8'd1,  1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b1, "R9 m3");
        step(1'b1, 10'd6, 8'd1,  1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b1, "R8 m4");
        step(1'b1, 10'd6, 8'd1,  1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "R8 m5");
        step(1'b0, 10'd6, 8'd1,  1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "R8 m6");
        step(1'b0, 10'd6, 8'd1,  1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "R8 m7");
        step(1'b0, 10'd6, 8'd1,  1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b0, "R9 m8");
        step(1'b0, 10'd6, 8'd1,  1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b1, "R9 m9");
        step(1'b0, 10'd6, 8'd1,  1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b1, "R10 m10");
        step(1'b0, 10'd6, 8'd1,  1'b1, 1'b1, 1'b0, 10'd0, 8'd0, 1'b0, 1'b1, "R10 m11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule